// File: doc/BRIEF.md
# Output frame playback latency controller

This block sits between a frame-oriented DMA write port and a DAC sample interface. Sample words arrive in bursts that fill one of two frame banks. A separate conversion strobe draws one word per pulse from the bank that is currently playing and loads it into the registered DAC output. While one bank plays, the other bank fills.

A static mode input sets when a fully received frame is released for playback. In immediate mode a frame can be played as soon as its last word has been written. This gives the shortest delay, but that delay varies with the transfer time. In hit-aligned mode a full frame waits for the next sample-hit pulse before it is released. The delay from the hit to the first output word is then the same every time, at the cost of roughly one extra frame of latency. In either mode, a strobe that finds no released data leaves the output at its last value. After the first word has been played, such a strobe also raises a sticky underrun flag. A one-cycle pulse marks the output of the last word of each frame.

Top module: `frame_playback_ctrl`

## Requirements
- R1: After a synchronous reset, `dac_data` is zero, `dac_update`, `frame_done` and `underrun` are low, and no bank holds a frame, so `wr_ready` is high.
- R2: Accepted words (`wr_valid` and `wr_ready` both high at an edge) fill the current bank in order. The word accepted at index `cfg_len_m1` completes the bank, so the frame length is `cfg_len_m1`+1, from 1 to 256. `wr_ready` is low while the bank to be filled still holds an unplayed frame, and words offered while it is low are ignored.
- R3: With `cfg_next_hit`=0, a strobe sampled at any edge after the edge that accepted a frame's last word loads that frame's first word into `dac_data` at that edge. Each later strobe loads the next word.
- R4: With `cfg_next_hit`=1, a full frame is not played until `sample_hit` has been sampled high at an edge after the frame was completed. Strobes before that release leave `dac_data` unchanged. The first strobe at an edge after the release loads the frame's first word.
- R5: A strobe that finds no released frame leaves `dac_data` unchanged and keeps `dac_update` low.
- R6: `underrun` is set at any edge where a strobe finds no released frame, provided at least one word has been played since reset. It stays set until `underrun_clr` is sampled high. If both happen at the same edge, the set wins.
- R7: `frame_done` pulses for exactly the cycle in which the last word of a frame appears on `dac_data`, together with `dac_update`.
- R8: Frames play in arrival order, alternating between the banks. If the next frame is already released, the strobe after a frame's last word loads the next frame's first word, with no held strobe in between.
- R9: `dac_update` is high for one cycle after each edge at which `dac_data` loads a word, and `dac_data` changes at no other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_next_hit | input | 1 | Release policy: 0 immediate, 1 aligned to sample hit (static) |
| cfg_len_m1 | input | IDX_W | Frame length minus one (static) |
| wr_valid | input | 1 | DMA word offered |
| wr_data | input | DATA_W | DMA sample word |
| wr_ready | output | 1 | Current fill bank can accept words |
| conv_strobe | input | 1 | Conversion strobe, one output word per pulse |
| sample_hit | input | 1 | Sample-hit pulse, used in aligned mode |
| underrun_clr | input | 1 | Write-one clear of the underrun flag |
| dac_data | output | DATA_W | Registered DAC sample value |
| dac_update | output | 1 | `dac_data` loaded a new word at the last edge |
| frame_done | output | 1 | Last word of a frame was loaded at the last edge |
| underrun | output | 1 | Sticky flag: a strobe found no data |

## Verification
The hardest condition to reach is the frame boundary in which one bank is freed while the other is already full. Reaching it requires two complete frames queued ahead of playback, so that both banks are full and `wr_ready` is low. The bench writes two frames back to back and then offers a stray word while `wr_ready` is low. It then strobes straight across the boundary and checks that no stray word appears and no underrun is raised. In aligned mode, the bench completes a second frame but withholds the sample hit, which shows the hold at a frame boundary.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
  typedef enum logic {
    REL_IMMEDIATE = 1'b0,
    REL_NEXT_HIT  = 1'b1
  } rel_mode_e;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/fpl_bank_mem.sv
module fpl_bank_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  // registered read port doubles as the DAC output register
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/fpl_fill_ctrl.sv
module fpl_fill_ctrl #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W-1:0]      cfg_len_m1,
  input  logic                  wr_valid,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [NUM_BANKS-1:0]  bank_valid,
  output logic                  wr_ready,
  output logic                  mem_we,
  output logic [IDX_W:0]        mem_waddr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic                  fill_done,
  output logic                  fill_bank
);
  logic [IDX_W-1:0] wr_idx_q;
  logic             fill_bank_q;
  logic             accept;
  logic             at_last;

  assign wr_ready  = ~bank_valid[fill_bank_q];
  assign accept    = wr_valid & wr_ready;
  assign at_last   = (wr_idx_q == cfg_len_m1);
  assign mem_we    = accept;
  assign mem_waddr = {fill_bank_q, wr_idx_q};
  assign mem_wdata = wr_data;
  assign fill_done = accept & at_last;
  assign fill_bank = fill_bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx_q    <= '0;
      fill_bank_q <= 1'b0;
    end else if (accept) begin
      if (at_last) begin
        wr_idx_q    <= '0;
        fill_bank_q <= ~fill_bank_q;
      end else begin
        wr_idx_q <= wr_idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpl_player.sv
module fpl_player
  import fpl_pkg::*;
#(
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  rel_mode_e             cfg_mode,
  input  logic [IDX_W-1:0]      cfg_len_m1,
  input  logic                  conv_strobe,
  input  logic                  sample_hit,
  input  logic                  underrun_clr,
  input  logic                  fill_done,
  input  logic                  fill_bank,
  output logic [NUM_BANKS-1:0]  bank_valid,
  output logic                  mem_re,
  output logic [IDX_W:0]        mem_raddr,
  output logic                  dac_update,
  output logic                  frame_done,
  output logic                  underrun
);
  logic [NUM_BANKS-1:0] bank_rel;
  logic                 play_bank_q;
  logic [IDX_W-1:0]     rd_idx_q;
  logic                 armed_q;
  logic                 underrun_q;
  logic                 update_q;
  logic                 done_q;
  logic                 playing;
  logic                 rd_last;
  logic                 free_bank;

  assign playing   = bank_valid[play_bank_q] & bank_rel[play_bank_q];
  assign mem_re    = conv_strobe & playing;
  assign mem_raddr = {play_bank_q, rd_idx_q};
  assign rd_last   = (rd_idx_q == cfg_len_m1);
  assign free_bank = mem_re & rd_last;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic valid_q;
    logic rel_q;
    logic set_full;
    logic clr_bank;

    assign set_full = fill_done & (fill_bank == b[0]);
    assign clr_bank = free_bank & (play_bank_q == b[0]);

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q <= 1'b0;
        rel_q   <= 1'b0;
      end else begin
        if (set_full)      valid_q <= 1'b1;
        else if (clr_bank) valid_q <= 1'b0;

        if (clr_bank)
          rel_q <= 1'b0;
        else if (cfg_mode == REL_IMMEDIATE && set_full)
          rel_q <= 1'b1;
        else if (cfg_mode == REL_NEXT_HIT && sample_hit && valid_q)
          rel_q <= 1'b1;
      end
    end

    assign bank_valid[b] = valid_q;
    assign bank_rel[b]   = rel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      play_bank_q <= 1'b0;
      rd_idx_q    <= '0;
      armed_q     <= 1'b0;
      underrun_q  <= 1'b0;
      update_q    <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      update_q <= mem_re;
      done_q   <= free_bank;
      if (mem_re) begin
        armed_q <= 1'b1;
        if (rd_last) begin
          rd_idx_q    <= '0;
          play_bank_q <= ~play_bank_q;
        end else begin
          rd_idx_q <= rd_idx_q + 1'b1;
        end
      end
      if (conv_strobe && !playing && armed_q) underrun_q <= 1'b1;
      else if (underrun_clr)                  underrun_q <= 1'b0;
    end
  end

  assign dac_update = update_q;
  assign frame_done = done_q;
  assign underrun   = underrun_q;
endmodule

// File: rtl/frame_playback_ctrl.sv
module frame_playback_ctrl
  import fpl_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned MAX_LEN = 256,
  localparam int unsigned IDX_W  = $clog2(MAX_LEN),
  localparam int unsigned ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_next_hit,
  input  logic [IDX_W-1:0]  cfg_len_m1,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              conv_strobe,
  input  logic              sample_hit,
  input  logic              underrun_clr,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_update,
  output logic              frame_done,
  output logic              underrun
);
  logic [NUM_BANKS-1:0] bank_valid;
  logic                 mem_we;
  logic [ADDR_W-1:0]    mem_waddr;
  logic [DATA_W-1:0]    mem_wdata;
  logic                 mem_re;
  logic [ADDR_W-1:0]    mem_raddr;
  logic                 fill_done;
  logic                 fill_bank;
  rel_mode_e            mode;

  assign mode = cfg_next_hit ? REL_NEXT_HIT : REL_IMMEDIATE;

  fpl_fill_ctrl #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_BANKS(NUM_BANKS)
  ) u_fill (
    .clk(clk), .rst(rst), .cfg_len_m1(cfg_len_m1),
    .wr_valid(wr_valid), .wr_data(wr_data), .bank_valid(bank_valid),
    .wr_ready(wr_ready), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .fill_done(fill_done), .fill_bank(fill_bank)
  );

  fpl_player #(
    .IDX_W(IDX_W), .NUM_BANKS(NUM_BANKS)
  ) u_play (
    .clk(clk), .rst(rst), .cfg_mode(mode), .cfg_len_m1(cfg_len_m1),
    .conv_strobe(conv_strobe), .sample_hit(sample_hit),
    .underrun_clr(underrun_clr), .fill_done(fill_done),
    .fill_bank(fill_bank), .bank_valid(bank_valid), .mem_re(mem_re),
    .mem_raddr(mem_raddr), .dac_update(dac_update),
    .frame_done(frame_done), .underrun(underrun)
  );

  fpl_bank_mem #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .re(mem_re), .raddr(mem_raddr), .rdata(dac_data)
  );
endmodule

// File: rtl/fpl_checker.sv
module fpl_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_strobe,
  input logic              underrun_clr,
  input logic [DATA_W-1:0] dac_data,
  input logic              dac_update,
  input logic              frame_done,
  input logic              underrun
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (dac_data == '0 && !dac_update && !frame_done && !underrun)); // R1

  AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_data) |-> dac_update); // R5

  AST_UPDATE_FROM_STROBE: assert property (@(posedge clk) disable iff (rst)
    dac_update |-> $past(conv_strobe)); // R9

  AST_DONE_WITH_UPDATE: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> dac_update); // R7

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (underrun && !underrun_clr) |=> underrun); // R6

  AST_UNDERRUN_ON_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> ($past(conv_strobe) && !dac_update)); // R6
endmodule

bind frame_playback_ctrl fpl_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .conv_strobe(conv_strobe),
  .underrun_clr(underrun_clr), .dac_data(dac_data),
  .dac_update(dac_update), .frame_done(frame_done), .underrun(underrun)
);

// File: tb/frame_playback_ctrl_tb.sv
module frame_playback_ctrl_tb;
  localparam int unsigned DW  = 16;
  localparam int unsigned IW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_next_hit = 1'b0;
  logic [IW-1:0] cfg_len_m1 = 8'd3;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready;
  logic          conv_strobe = 1'b0;
  logic          sample_hit = 1'b0;
  logic          underrun_clr = 1'b0;
  logic [DW-1:0] dac_data;
  logic          dac_update;
  logic          frame_done;
  logic          underrun;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  frame_playback_ctrl #(.DATA_W(DW), .MAX_LEN(256)) u_dut (
    .clk(clk), .rst(rst), .cfg_next_hit(cfg_next_hit), .cfg_len_m1(cfg_len_m1),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .conv_strobe(conv_strobe), .sample_hit(sample_hit),
    .underrun_clr(underrun_clr), .dac_data(dac_data), .dac_update(dac_update),
    .frame_done(frame_done), .underrun(underrun)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode, input logic [IW-1:0] len_m1);
    @(negedge clk);
    rst = 1'b1; cfg_next_hit = mode; cfg_len_m1 = len_m1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push_frame(input int n, input int base, input int step);
    for (int i = 0; i < n; i++) begin
      while (!wr_ready) @(negedge clk);
      wr_valid = 1'b1; wr_data = DW'(base + i * step);
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  task automatic strobe();
    conv_strobe = 1'b1;
    @(negedge clk);
    conv_strobe = 1'b0;
  endtask

  task automatic pulse_hit();
    sample_hit = 1'b1;
    @(negedge clk);
    sample_hit = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 8'd3);
    chk("R1 dac_data", 32'(dac_data), 0);
    chk("R1 wr_ready", 32'(wr_ready), 1);
    chk("R1 flags", {29'd0, dac_update, frame_done, underrun}, 0);
  endtask

  task automatic t_immediate();
    do_reset(1'b0, 8'd3);
    strobe();
    chk("R6 not armed", 32'(underrun), 0);
    chk("R5 idle hold", 32'(dac_data), 0);
    push_frame(4, 32'h100, 1);
    for (int i = 0; i < 4; i++) begin
      strobe();
      chk("R3 word", 32'(dac_data), 32'h100 + i);
      chk("R9 update", 32'(dac_update), 1);
      chk("R7 done", 32'(frame_done), (i == 3) ? 1 : 0);
    end
    @(negedge clk);
    chk("R9 pulse ends", 32'(dac_update), 0);
    strobe();
    chk("R5 held value", 32'(dac_data), 32'h103);
    chk("R5 no update", 32'(dac_update), 0);
    chk("R6 set", 32'(underrun), 1);
    repeat (3) @(negedge clk);
    chk("R6 sticky", 32'(underrun), 1);
    underrun_clr = 1'b1; conv_strobe = 1'b1;
    @(negedge clk);
    underrun_clr = 1'b0; conv_strobe = 1'b0;
    chk("R6 set wins", 32'(underrun), 1);
    underrun_clr = 1'b1;
    @(negedge clk);
    underrun_clr = 1'b0;
    chk("R6 cleared", 32'(underrun), 0);
  endtask

  task automatic t_pingpong();
    do_reset(1'b0, 8'd3);
    push_frame(4, 32'h200, 1);
    push_frame(4, 32'h300, 1);
    chk("R2 both full", 32'(wr_ready), 0);
    wr_valid = 1'b1; wr_data = 16'hDEAD;
    @(negedge clk);
    wr_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      strobe();
      chk("R8 order", 32'(dac_data), (i < 4) ? 32'h200 + i : 32'h300 + i - 4);
      chk("R8 no gap", 32'(dac_update), 1);
    end
    chk("R8 no underrun", 32'(underrun), 0);
    chk("R2 ready again", 32'(wr_ready), 1);
  endtask

  task automatic t_next_hit();
    do_reset(1'b1, 8'd3);
    push_frame(4, 32'h400, 2);
    strobe();
    chk("R4 wait hit", 32'(dac_data), 0);
    chk("R4 no update", 32'(dac_update), 0);
    pulse_hit();
    strobe();
    chk("R4 first after hit", 32'(dac_data), 32'h400);
    for (int i = 1; i < 4; i++) begin
      strobe();
      chk("R4 word", 32'(dac_data), 32'h400 + 2 * i);
    end
    push_frame(4, 32'h500, 1);
    strobe();
    chk("R4 boundary hold", 32'(dac_data), 32'h406);
    chk("R6 aligned underrun", 32'(underrun), 1);
    pulse_hit();
    strobe();
    chk("R4 second frame", 32'(dac_data), 32'h500);
  endtask

  task automatic t_lengths();
    do_reset(1'b0, 8'd255);
    push_frame(256, 7, 3);
    for (int i = 0; i < 256; i++) begin
      strobe();
      chk("R2 len256 word", 32'(dac_data), 32'(DW'(7 + 3 * i)));
      chk("R7 len256 done", 32'(frame_done), (i == 255) ? 1 : 0);
    end
    do_reset(1'b0, 8'd0);
    push_frame(1, 32'h6A, 1);
    push_frame(1, 32'h6B, 1);
    strobe();
    chk("R2 len1 word", 32'(dac_data), 32'h6A);
    chk("R7 len1 done", 32'(frame_done), 1);
    strobe();
    chk("R8 len1 next", 32'(dac_data), 32'h6B);
  endtask

  initial begin
    t_reset();
    t_immediate();
    t_pingpong();
    t_next_hit();
    t_lengths();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule